// File: doc/BRIEF.md
# Head Step Sequencer

This block moves the read/write heads of up to four floppy drives. A host-side controller hands it one command at a time: either a seek to a target cylinder or a recalibrate (return to cylinder 0), together with a drive number and a 4-bit step-rate code. The block keeps a present-cylinder register for every drive. It sets the direction level, waits for that level to settle, and then emits step pulses at the programmed spacing. When the head arrives, or when the track-zero sensor reports cylinder 0, it raises a one-cycle completion interrupt. A recalibrate that never sees track zero gives up after a fixed number of pulses and reports an equipment fault.

The controller is a five-state machine. IDLE accepts a command (IDLE→SETTLE). SETTLE holds the new direction for `SETTLE_CLKS` clocks. It then either finishes at once when the head is already in place (SETTLE→DONE) or starts stepping (SETTLE→PULSE). PULSE drives the step line high for `PULSE_CLKS` clocks (PULSE→DWELL). DWELL fills out the rest of the step interval and then either steps again (DWELL→PULSE) or finishes (DWELL→DONE). DONE lasts one cycle, raises the interrupt, and returns to IDLE (DONE→IDLE). All timing counts are in clocks. `UNIT_CLKS` is the number of clocks in one rate unit, so running the same count on a clock half as fast doubles every interval.

Top module: `head_step_seq`

## Requirements
- R1: Consecutive step pulses of one command start exactly U×`UNIT_CLKS` clocks apart. U is 16 minus the rate code, and code 0 gives 16. The code is captured when the command is accepted, so later changes to the input have no effect on a running command.
- R2: `dir_out` is 1 (inward) when a seek target is above the present cylinder. It is 0 for outward seeks and for recalibrate. It is set in the accept cycle, stays unchanged until the command ends, and the first step pulse rises no earlier than `SETTLE_CLKS` clocks after accept.
- R3: Each step pulse stays high for exactly `PULSE_CLKS` clocks.
- R4: A seek emits |target − present| pulses and leaves the present cylinder equal to the target. A seek to the present cylinder emits no pulse and still completes.
- R5: Recalibrate steps outward until `track0` is found high at the end of a step interval, or is already high after the settle time. It then sets the present cylinder to 0.
- R6: If `track0` is still low at the end of the interval after the 77th pulse, recalibrate completes with `equip_chk` high and leaves the present cylinder unchanged.
- R7: Completion raises `irq` for one cycle, with `seek_end` high and `irq_drive` giving the drive.
- R8: `busy` bit n is high for drive n from the cycle after accept through the completion cycle. At most one bit is high.
- R9: `seek_mode` is high from accept through the completion cycle and low otherwise. `step_out` is high only while `seek_mode` is high.
- R10: `low_current` is high exactly when the present cylinder of the selected drive (`unit_sel`) is 42 or more.
- R11: A command presented while a command is running gives a one-cycle `cmd_reject` in the next cycle and leaves the running command's drive, target and outcome unchanged.
- R12: After reset, every present cylinder is 0 and `step_out`, `seek_mode`, `busy`, `irq` and `cmd_reject` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_recal | input | 1 | 1 = recalibrate, 0 = seek |
| cmd_drive | input | 2 | Drive number of the command |
| cmd_cyl | input | 8 | Seek target cylinder |
| rate_code | input | 4 | Step-rate code, captured at accept |
| track0 | input | 1 | Track-zero sense of the selected drive |
| query_drive | input | 2 | Drive whose present cylinder is shown on `query_cyl` |
| step_out | output | 1 | Step pulse |
| dir_out | output | 1 | Step direction, 1 = inward |
| seek_mode | output | 1 | High while a positioning command runs |
| unit_sel | output | 2 | Drive selected by the last accepted command |
| low_current | output | 1 | Selected head at cylinder 42 or beyond |
| busy | output | 4 | Per-drive positioning-in-progress bits |
| irq | output | 1 | Completion interrupt, one cycle |
| irq_drive | output | 2 | Drive that completed |
| seek_end | output | 1 | Completion flag, valid with `irq` |
| equip_chk | output | 1 | Recalibrate failed, valid with `irq` |
| cmd_reject | output | 1 | Command refused because the block was busy |
| query_cyl | output | 8 | Present cylinder of `query_drive` |

## Verification
The hardest case to reach from the ports is the 77-pulse give-up. It needs a head that never reports track zero, and a recalibrate that runs out of pulses only happens when the drive's real position is far from what its register holds. The bench models each head's physical position from the observed pulses and drives `track0` from that model. It starts some drives with a random offset between the physical position and the register, so long recalibrates and over-limit failures come up naturally. It also forces a stuck-low sensor in one directed case. A second awkward case is a command arriving mid-step. The bench injects one for the same drive and one for another drive during a long seek, and confirms the running seek still lands on its own target.

// File: rtl/head_step_pkg.sv
package head_step_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_PULSE,
        ST_DWELL,
        ST_DONE
    } step_state_t;

    // pulses a recalibrate may issue before reporting a fault
    localparam int RECAL_LIMIT = 77;
    // cylinder at which the reduced write current request starts
    localparam int LOW_CUR_CYL = 42;
    localparam int RECAL_CNT_W = 7;

endpackage

// File: rtl/head_step_rate.sv
module head_step_rate #(
    parameter int UNIT_CLKS = 8000,
    parameter int CNT_W     = 17
) (
    input  logic [3:0]       code,
    output logic [CNT_W-1:0] interval
);
    logic [4:0] units;

    // inverted code: F is the shortest spacing, 0 wraps to the longest
    always_comb begin
        if (code == 4'd0)
            units = 5'd16;
        else
            units = 5'd16 - {1'b0, code};
        interval = CNT_W'(units) * CNT_W'(UNIT_CLKS);
    end
endmodule

// File: rtl/head_step_cylbank.sv
module head_step_cylbank #(
    parameter int NDRV  = 4,
    parameter int CYL_W = 8,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [CYL_W-1:0] wr_val,
    input  logic [SEL_W-1:0] rd_a_sel,
    input  logic [SEL_W-1:0] rd_b_sel,
    input  logic [SEL_W-1:0] rd_c_sel,
    output logic [CYL_W-1:0] rd_a,
    output logic [CYL_W-1:0] rd_b,
    output logic [CYL_W-1:0] rd_c
);
    logic [CYL_W-1:0] cyl [NDRV];

    for (genvar g = 0; g < NDRV; g++) begin : g_cyl
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cyl[g] <= '0;
            else if (wr_en && wr_sel == SEL_W'(g))
                cyl[g] <= wr_val;
        end
    end

    assign rd_a = cyl[rd_a_sel];
    assign rd_b = cyl[rd_b_sel];
    assign rd_c = cyl[rd_c_sel];
endmodule

// File: rtl/head_step_seq.sv
module head_step_seq
    import head_step_pkg::*;
#(
    parameter int NDRV        = 4,
    parameter int CYL_W       = 8,
    parameter int UNIT_CLKS   = 8000,
    parameter int SETTLE_CLKS = 64,
    parameter int PULSE_CLKS  = 56
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_valid,
    input  logic                    cmd_recal,
    input  logic [$clog2(NDRV)-1:0] cmd_drive,
    input  logic [CYL_W-1:0]        cmd_cyl,
    input  logic [3:0]              rate_code,
    input  logic                    track0,
    input  logic [$clog2(NDRV)-1:0] query_drive,
    output logic                    step_out,
    output logic                    dir_out,
    output logic                    seek_mode,
    output logic [$clog2(NDRV)-1:0] unit_sel,
    output logic                    low_current,
    output logic [NDRV-1:0]         busy,
    output logic                    irq,
    output logic [$clog2(NDRV)-1:0] irq_drive,
    output logic                    seek_end,
    output logic                    equip_chk,
    output logic                    cmd_reject,
    output logic [CYL_W-1:0]        query_cyl
);
    localparam int SEL_W = $clog2(NDRV);
    localparam int CNT_W = $clog2(16 * UNIT_CLKS + 1);

    step_state_t state, nxt;

    logic [CNT_W-1:0]       cnt;
    logic [CNT_W-1:0]       interval;
    logic [SEL_W-1:0]       drv;
    logic [CYL_W-1:0]       tgt;
    logic                   recal_q;
    logic                   dir_q;
    logic                   fail_q;
    logic                   reject_q;
    logic [3:0]             rate_q;
    logic [RECAL_CNT_W-1:0] rcnt;

    logic [CYL_W-1:0] cur_cyl;
    logic [CYL_W-1:0] new_drv_cyl;
    logic             wr_en;
    logic [CYL_W-1:0] wr_val;

    logic accept, settle_end, pulse_end, dwell_end, arrived, give_up;

    head_step_rate #(.UNIT_CLKS(UNIT_CLKS), .CNT_W(CNT_W)) u_rate (
        .code     (rate_q),
        .interval (interval)
    );

    head_step_cylbank #(.NDRV(NDRV), .CYL_W(CYL_W), .SEL_W(SEL_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (drv),
        .wr_val   (wr_val),
        .rd_a_sel (drv),
        .rd_b_sel (cmd_drive),
        .rd_c_sel (query_drive),
        .rd_a     (cur_cyl),
        .rd_b     (new_drv_cyl),
        .rd_c     (query_cyl)
    );

    // condition decode
    always_comb begin
        accept     = (state == ST_IDLE) && cmd_valid;
        settle_end = (cnt == CNT_W'(SETTLE_CLKS - 1));
        pulse_end  = (cnt == CNT_W'(PULSE_CLKS - 1));
        dwell_end  = (cnt == interval - CNT_W'(PULSE_CLKS + 1));
        arrived    = recal_q ? track0 : (cur_cyl == tgt);
        give_up    = recal_q && !track0 && (rcnt == RECAL_CNT_W'(RECAL_LIMIT));
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (cmd_valid) nxt = ST_SETTLE;
            ST_SETTLE: if (settle_end) nxt = arrived ? ST_DONE : ST_PULSE;
            ST_PULSE:  if (pulse_end) nxt = ST_DWELL;
            ST_DWELL:  if (dwell_end) nxt = (arrived || give_up) ? ST_DONE : ST_PULSE;
            ST_DONE:   nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // state register and command context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            drv      <= '0;
            tgt      <= '0;
            recal_q  <= 1'b0;
            dir_q    <= 1'b0;
            fail_q   <= 1'b0;
            reject_q <= 1'b0;
            rate_q   <= 4'd0;
            rcnt     <= '0;
        end else begin
            state    <= nxt;
            cnt      <= (nxt != state) ? '0 : cnt + CNT_W'(1);
            reject_q <= cmd_valid && (state != ST_IDLE);
            if (accept) begin
                drv     <= cmd_drive;
                tgt     <= cmd_cyl;
                recal_q <= cmd_recal;
                rate_q  <= rate_code;
                dir_q   <= !cmd_recal && (cmd_cyl > new_drv_cyl);
                fail_q  <= 1'b0;
                rcnt    <= '0;
            end
            if (state == ST_PULSE && pulse_end)
                rcnt <= rcnt + RECAL_CNT_W'(1);
            if (state == ST_DWELL && dwell_end && !arrived && give_up)
                fail_q <= 1'b1;
        end
    end

    // present-cylinder update: per pulse on seeks, zero on recalibrate success
    always_comb begin
        wr_en  = (state == ST_PULSE && pulse_end && !recal_q) ||
                 (state == ST_DONE && recal_q && !fail_q);
        if (recal_q)
            wr_val = '0;
        else if (dir_q)
            wr_val = cur_cyl + CYL_W'(1);
        else
            wr_val = cur_cyl - CYL_W'(1);
    end

    // outputs
    always_comb begin
        step_out    = (state == ST_PULSE);
        seek_mode   = (state != ST_IDLE);
        dir_out     = dir_q;
        unit_sel    = drv;
        low_current = (cur_cyl >= CYL_W'(LOW_CUR_CYL));
        irq         = (state == ST_DONE);
        irq_drive   = drv;
        seek_end    = (state == ST_DONE);
        equip_chk   = (state == ST_DONE) && fail_q;
        cmd_reject  = reject_q;
        for (int i = 0; i < NDRV; i++)
            busy[i] = (state != ST_IDLE) && (drv == SEL_W'(i));
    end
endmodule

// File: rtl/head_step_chk.sv
module head_step_chk #(
    parameter int NDRV = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            step_out,
    input logic            dir_out,
    input logic            seek_mode,
    input logic [NDRV-1:0] busy,
    input logic            irq,
    input logic            seek_end,
    input logic            equip_chk,
    input logic            cmd_reject
);
    p_step_in_seek_r9: assert property (@(posedge clk) disable iff (!rst_n)
        step_out |-> seek_mode);

    p_irq_ends_seek_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !seek_mode);

    p_busy_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(busy));

    p_busy_in_seek_r8: assert property (@(posedge clk) disable iff (!rst_n)
        seek_mode |-> (busy != '0));

    p_dir_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (seek_mode && $past(seek_mode)) |-> $stable(dir_out));

    p_irq_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> seek_end);

    p_irq_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    p_fault_at_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        equip_chk |-> irq);

    p_reject_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reject |-> $past(seek_mode));
endmodule

bind head_step_seq head_step_chk #(.NDRV(NDRV)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_out   (step_out),
    .dir_out    (dir_out),
    .seek_mode  (seek_mode),
    .busy       (busy),
    .irq        (irq),
    .seek_end   (seek_end),
    .equip_chk  (equip_chk),
    .cmd_reject (cmd_reject)
);

// File: tb/sim_head_step_seq.sv
module sim_head_step_seq;
    localparam int UNIT   = 4;
    localparam int SETTLE = 3;
    localparam int PW     = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic       cmd_recal = 1'b0;
    logic [1:0] cmd_drive = 2'd0;
    logic [7:0] cmd_cyl = 8'd0;
    logic [3:0] rate_code = 4'd0;
    logic       track0;
    logic [1:0] query_drive = 2'd0;
    logic       step_out, dir_out, seek_mode, low_current, irq, seek_end, equip_chk, cmd_reject;
    logic [1:0] unit_sel, irq_drive;
    logic [3:0] busy;
    logic [7:0] query_cyl;

    int  checks = 0;
    int  fails = 0;
    int  cyc = 0;
    bit  finished = 0;
    bit  fault = 0;
    int  phys [4];
    int  pcn_m [4];
    int  pulses = 0;
    int  last_rise = 0;
    int  accept_cyc = 0;
    int  exp_int = 0;
    bit  exp_dir = 0;
    bit  step_d = 0;
    int  e_pulses, e_cyl, e_drv;
    bit  e_eq;
    int  seed_v;

    always #5 clk = ~clk;

    assign track0 = !fault && (phys[unit_sel] == 0);

    head_step_seq #(.UNIT_CLKS(UNIT), .SETTLE_CLKS(SETTLE), .PULSE_CLKS(PW)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_recal(cmd_recal),
        .cmd_drive(cmd_drive), .cmd_cyl(cmd_cyl), .rate_code(rate_code),
        .track0(track0), .query_drive(query_drive), .step_out(step_out),
        .dir_out(dir_out), .seek_mode(seek_mode), .unit_sel(unit_sel),
        .low_current(low_current), .busy(busy), .irq(irq), .irq_drive(irq_drive),
        .seek_end(seek_end), .equip_chk(equip_chk), .cmd_reject(cmd_reject),
        .query_cyl(query_cyl)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int units_of(input int code);
        return (code == 0) ? 16 : 16 - code;
    endfunction

    // pulse monitor and head position model
    always @(negedge clk) begin
        if (rst_n) begin
            if (step_out && !step_d) begin
                if (pulses == 0)
                    chk(cyc - accept_cyc >= SETTLE, "R2 settle before first pulse", cyc - accept_cyc, SETTLE);
                else
                    chk(cyc - last_rise == exp_int, "R1 step interval", cyc - last_rise, exp_int);
                chk(dir_out == exp_dir, "R2 direction at pulse", int'(dir_out), int'(exp_dir));
                chk(busy != 4'd0, "R9 step only in seek mode", int'(busy), 1);
                pulses++;
                last_rise = cyc;
                if (dir_out) phys[unit_sel]++;
                else if (phys[unit_sel] > 0) phys[unit_sel]--;
            end
            if (!step_out && step_d)
                chk(cyc - last_rise == PW, "R3 pulse width", cyc - last_rise, PW);
        end
        step_d = step_out;
    end

    task automatic start_cmd(input bit rc, input int d, input int c, input int r);
        @(negedge clk);
        pulses  = 0;
        exp_int = units_of(r) * UNIT;
        e_drv   = d;
        if (rc) begin
            exp_dir  = 0;
            e_eq     = fault || (phys[d] > 77);
            e_pulses = e_eq ? 77 : phys[d];
            e_cyl    = e_eq ? pcn_m[d] : 0;
        end else begin
            exp_dir  = (c > pcn_m[d]);
            e_eq     = 0;
            e_pulses = (c > pcn_m[d]) ? c - pcn_m[d] : pcn_m[d] - c;
            e_cyl    = c;
        end
        cmd_valid   = 1'b1;
        cmd_recal   = rc;
        cmd_drive   = 2'(d);
        cmd_cyl     = 8'(c);
        rate_code   = 4'(r);
        query_drive = 2'(d);
        @(posedge clk);
        #1 accept_cyc = cyc;
        @(negedge clk);
        cmd_valid = 1'b0;
        rate_code = 4'($urandom_range(0, 15));   // R1: must not disturb the running command
        chk(cmd_reject == 1'b0, "R11 no reject when idle", int'(cmd_reject), 0);
        chk(busy == 4'(1 << d), "R8 busy bit of drive", int'(busy), 1 << d);
    endtask

    task automatic finish_cmd();
        int t = 0;
        while (!irq && t < 40000) begin
            @(negedge clk);
            t++;
        end
        chk(irq == 1'b1, "R7 completion interrupt", int'(irq), 1);
        chk(irq_drive == 2'(e_drv), "R7 interrupt drive", int'(irq_drive), e_drv);
        chk(seek_end == 1'b1, "R7 seek end flag", int'(seek_end), 1);
        chk(equip_chk == e_eq, "R6 equipment check flag", int'(equip_chk), int'(e_eq));
        chk(seek_mode == 1'b1, "R9 seek mode through completion", int'(seek_mode), 1);
        chk(busy == 4'(1 << e_drv), "R8 busy at completion", int'(busy), 1 << e_drv);
        chk(pulses == e_pulses, e_eq ? "R6 pulse count" : "R4 R5 pulse count", pulses, e_pulses);
        @(negedge clk);
        chk(int'(query_cyl) == e_cyl, "R4 R5 present cylinder", int'(query_cyl), e_cyl);
        chk(busy == 4'd0 && seek_mode == 1'b0 && irq == 1'b0, "R9 idle after completion",
            int'({seek_mode, busy}), 0);
        chk(low_current == (e_cyl >= 42), "R10 low current", int'(low_current), int'(e_cyl >= 42));
        pcn_m[e_drv] = e_cyl;
    endtask

    task automatic run_cmd(input bit rc, input int d, input int c, input int r);
        start_cmd(rc, d, c, r);
        finish_cmd();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        seed_v = $urandom(32'd20240611);
        phys[0] = 0;
        for (int i = 1; i < 4; i++) phys[i] = $urandom_range(1, 20);
        for (int i = 0; i < 4; i++) pcn_m[i] = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk(step_out == 0 && seek_mode == 0 && irq == 0 && cmd_reject == 0, "R12 outputs after reset",
            int'({step_out, seek_mode, irq, cmd_reject}), 0);
        chk(busy == 4'd0, "R12 busy after reset", int'(busy), 0);
        for (int i = 0; i < 4; i++) begin
            query_drive = 2'(i);
            #1 chk(query_cyl == 8'd0, "R12 present cylinder after reset", int'(query_cyl), 0);
        end

        // directed corner cases
        run_cmd(0, 0, 0, 15);     // R4 seek to present cylinder: no pulse
        run_cmd(1, 0, 0, 15);     // R5 recalibrate already at track zero
        run_cmd(0, 0, 45, 0);     // R1 code 0 = 16 units, R10 crosses 42
        run_cmd(0, 0, 41, 15);    // R2 outward, R10 drops below 42
        run_cmd(0, 0, 42, 14);    // R10 exactly 42
        run_cmd(1, 1, 0, 14);     // R5 recalibrate from a real offset
        fault = 1;
        run_cmd(1, 2, 0, 15);     // R6 sensor stuck low: 77 pulses then fault
        fault = 0;

        // R11 commands during a running seek are refused
        start_cmd(0, 3, 30, 15);
        repeat (2) @(negedge clk);
        cmd_valid = 1'b1; cmd_drive = 2'd3; cmd_cyl = 8'd5;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(cmd_reject == 1'b1, "R11 same-drive command refused", int'(cmd_reject), 1);
        cmd_valid = 1'b1; cmd_drive = 2'd1; cmd_recal = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_recal = 1'b0;
        chk(cmd_reject == 1'b1, "R11 other-drive command refused", int'(cmd_reject), 1);
        chk(busy == 4'b1000, "R11 running drive unchanged", int'(busy), 8);
        finish_cmd();

        // constrained random commands
        for (int k = 0; k < 14; k++) begin
            int d = $urandom_range(0, 3);
            bit rc = ($urandom_range(0, 3) == 0);
            run_cmd(rc, d, $urandom_range(0, 79), $urandom_range(0, 15));
        end

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule